// File: doc/BRIEF.md
# I2C Slave Controller with Clock-Stretch Hand-off

This block is the slave side of an I2C bus for a small controller. It runs on a fast system clock and samples SCL and SDA through a synchronizer. It recognises START and STOP conditions and keeps a bus-busy flag. After each START it takes in a 7-bit address and a direction bit, and it compares the address with the own address that the host programs. When the address matches, the block acknowledges it, raises its interrupt and holds SCL low. SCL stays low until the host logic services the transfer through a small register port. The bus drive is open-drain: the two outputs are pull-low enables.

After every acknowledged byte the slave again raises the interrupt and holds SCL. This applies both to a byte it has received and to a byte it has sent that the master acknowledged. In receive mode the host releases the clock by reading the receive data register; a dummy read is allowed. In transmit mode the host releases it by writing the next byte to send. The interrupt line has three causes. An address-match flag and a time-out flag let the host tell them apart; when neither flag is set, the cause is a finished data byte. A time-out counter watches for a transfer in which SCL stops toggling. When it expires, the block drops both bus lines, sets the time-out flag and interrupts the host.

The controller is written as one state machine. Its states are:
- ST_IDLE: waits for a START.
- ST_ADDR: shifts in the address and direction bit.
- ST_ACK: pulls SDA low for the ninth clock, after an address match or a received byte.
- ST_HOLD: stretches SCL and waits for the host.
- ST_RX: shifts in a data byte.
- ST_TX: drives a data byte.
- ST_TACK: samples the master's acknowledge.
- ST_NACK: leaves the bus alone until the next START or STOP.

Its transitions are:
- ST_IDLE→ST_ADDR on START.
- ST_ADDR→ST_ACK after the eighth bit, on an address match.
- ST_ADDR→ST_IDLE after the eighth bit, on a mismatch.
- ST_ACK→ST_HOLD on the falling edge that ends the acknowledge bit.
- ST_HOLD→ST_TX on a host write in transmit mode.
- ST_HOLD→ST_RX on a host read in receive mode.
- ST_RX→ST_ACK after eight bits.
- ST_TX→ST_TACK after eight bits.
- ST_TACK→ST_HOLD when the master acknowledges.
- ST_TACK→ST_NACK when the master does not acknowledge.
- Any state→ST_ADDR on a repeated START.
- Any state→ST_IDLE on STOP or on a time-out.

Top module: `i2c_stretch_slave`

## Requirements
- R1: After reset, irq, busy, addr_match, rw_flag and tout_flag are 0 and neither scl_oe nor sda_oe is asserted.
- R2: A START (SDA falls while SCL is high) sets busy. A STOP (SDA rises while SCL is high) clears busy and addr_match and returns the block to idle. While busy is 0 the block drives neither line.
- R3: The 7 bits after a START, MSB first, form the address. They are compared with own_addr. On a match the block pulls SDA low during the ninth clock. On a mismatch it does not acknowledge, does not interrupt and does not stretch.
- R4: The eighth bit after a START is latched into rw_flag; 1 means the master reads.
- R5: On an address match, the block sets addr_match and irq and holds SCL low from the end of the ninth clock. The hold ends on host_wr when tx_mode=1, or on host_rd when tx_mode=0. Ending the hold clears irq and addr_match. SCL is never held while irq is 0.
- R6: During a hold, a host_wr with tx_mode=0 or a host_rd with tx_mode=1 has no effect: SCL stays held and irq stays set.
- R7: In receive mode, a byte of 8 bits arrives MSB first and appears on host_rdata. The block acknowledges it with SDA low in the ninth clock. It then holds SCL and raises irq, with addr_match at 0.
- R8: In transmit mode, the byte written on host_wdata goes out MSB first. sda_oe changes only while SCL is low. After the master acknowledges (SDA low in the ninth clock), the block holds SCL and raises irq.
- R9: When the master does not acknowledge a transmitted byte, the block releases SDA, does not hold SCL and does not interrupt.
- R10: Outside idle, if SCL shows no edge for more than tout_limit cycles, the block sets tout_flag and irq, releases both lines and returns to idle. This applies whether SCL is held low or left high. irq_clr then clears tout_flag and irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low |
| own_addr | input | DATA_W-1 | Programmed slave address |
| tx_mode | input | 1 | 1: slave transmits, 0: slave receives |
| tout_limit | input | TOUT_W | Idle-SCL cycles tolerated before time-out |
| host_wr | input | 1 | Write strobe of the transmit data register |
| host_wdata | input | DATA_W | Byte to transmit |
| host_rd | input | 1 | Read strobe of the receive data register |
| host_rdata | output | DATA_W | Last received byte |
| irq_clr | input | 1 | Clears tout_flag, and irq outside a hold |
| irq | output | 1 | Interrupt request |
| busy | output | 1 | Bus-busy flag |
| addr_match | output | 1 | Current interrupt is an address match |
| rw_flag | output | 1 | Latched direction bit |
| tout_flag | output | 1 | Bus time-out occurred |

## Verification
Every one of the 256 possible first bytes after a START is sent to a fixed own address. This shows that exactly one address is acknowledged and that both direction bits land in rw_flag. A receive run uses sixteen arithmetic byte patterns and a transmit run uses eight. Together they separate correct bit order, acknowledge timing and per-byte stretching from shifted or reversed data. The last transmitted byte is refused by the master, so the release path can be told apart from the stretch path. Time-out is provoked once with SCL held by the slave and once with SCL abandoned high, which shows both watch conditions. The wrong host strobe is applied in each mode to show that it leaves the hold in place.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_HOLD,
        ST_RX,
        ST_TX,
        ST_TACK,
        ST_NACK
    } i2cs_state_e;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[s] <= '1;
                else        pipe[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[s] <= '1;
                else        pipe[s] <= pipe[s-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2cs_timer.sv
module i2cs_timer #(
    parameter int TOUT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              kick,
    input  logic [TOUT_W-1:0] limit,
    output logic              expire
);
    logic [TOUT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt_q <= '0;
        else if (!run || kick)    cnt_q <= '0;
        else if (cnt_q != '1)     cnt_q <= cnt_q + 1'b1;
    end

    assign expire = run && !kick && (cnt_q == limit);
endmodule

// File: rtl/i2c_stretch_slave.sv
module i2c_stretch_slave
    import i2cs_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int TOUT_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic [DATA_W-2:0] own_addr,
    input  logic              tx_mode,
    input  logic [TOUT_W-1:0] tout_limit,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_rd,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              irq_clr,
    output logic              irq,
    output logic              busy,
    output logic              addr_match,
    output logic              rw_flag,
    output logic              tout_flag
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] RX_LAST = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] TX_LAST = CNT_W'(DATA_W - 1);

    logic [1:0] line_s;
    logic       scl_s, sda_s, scl_p, sda_p;
    logic       scl_rise, scl_fall, start_c, stop_c;
    logic       tout_exp, host_go, addr_hit;

    i2cs_state_e       state_q, state_d;
    logic [CNT_W-1:0]  bit_q;
    logic [DATA_W-1:0] sh_q, rx_q;
    logic              rw_q, match_q, busy_q, ack_q, irq_q, tout_q;

    i2cs_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(line_s)
    );

    assign scl_s    = line_s[1];
    assign sda_s    = line_s[0];
    assign scl_rise = scl_s & ~scl_p;
    assign scl_fall = ~scl_s & scl_p;
    assign start_c  = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_c   = scl_s & scl_p & ~sda_p & sda_s;
    assign addr_hit = (sh_q[DATA_W-1:1] == own_addr);
    assign host_go  = (state_q == ST_HOLD) && (tx_mode ? host_wr : host_rd);

    i2cs_timer #(.TOUT_W(TOUT_W)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .run(state_q != ST_IDLE),
        .kick(scl_rise | scl_fall),
        .limit(tout_limit),
        .expire(tout_exp)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (tout_exp)     state_d = ST_IDLE;
        else if (start_c) state_d = ST_ADDR;
        else if (stop_c)  state_d = ST_IDLE;
        else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_ADDR: if (scl_fall && bit_q == RX_LAST)
                             state_d = addr_hit ? ST_ACK : ST_IDLE;
                ST_ACK:  if (scl_fall) state_d = ST_HOLD;
                ST_HOLD: if (host_go) state_d = tx_mode ? ST_TX : ST_RX;
                ST_RX:   if (scl_fall && bit_q == RX_LAST) state_d = ST_ACK;
                ST_TX:   if (scl_fall && bit_q == TX_LAST) state_d = ST_TACK;
                ST_TACK: if (scl_fall) state_d = ack_q ? ST_HOLD : ST_NACK;
                ST_NACK: ;
            endcase
        end
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            sh_q    <= '0;
            rx_q    <= '0;
            rw_q    <= 1'b0;
            match_q <= 1'b0;
            busy_q  <= 1'b0;
            ack_q   <= 1'b0;
            irq_q   <= 1'b0;
            tout_q  <= 1'b0;
            scl_p   <= 1'b1;
            sda_p   <= 1'b1;
        end else begin
            scl_p   <= scl_s;
            sda_p   <= sda_s;
            state_q <= state_d;

            if (start_c || state_d != state_q)
                bit_q <= '0;
            else if ((state_q == ST_ADDR || state_q == ST_RX) && scl_rise)
                bit_q <= bit_q + 1'b1;
            else if (state_q == ST_TX && scl_fall)
                bit_q <= bit_q + 1'b1;

            if (host_go && tx_mode)
                sh_q <= host_wdata;
            else if ((state_q == ST_ADDR || state_q == ST_RX) && scl_rise)
                sh_q <= {sh_q[DATA_W-2:0], sda_s};
            else if (state_q == ST_TX && scl_fall)
                sh_q <= {sh_q[DATA_W-2:0], 1'b1};

            if (state_q == ST_RX && state_d == ST_ACK)
                rx_q <= sh_q;

            if (state_q == ST_ADDR && state_d == ST_ACK) begin
                rw_q    <= sh_q[0];
                match_q <= 1'b1;
            end else if (start_c || stop_c || host_go) begin
                match_q <= 1'b0;
            end

            if (start_c)     busy_q <= 1'b1;
            else if (stop_c) busy_q <= 1'b0;

            if (state_q == ST_TACK && scl_rise)
                ack_q <= ~sda_s;

            if (tout_exp || (state_d == ST_HOLD && state_q != ST_HOLD))
                irq_q <= 1'b1;
            else if (host_go || (irq_clr && state_q != ST_HOLD))
                irq_q <= 1'b0;

            if (tout_exp)     tout_q <= 1'b1;
            else if (irq_clr) tout_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        scl_oe     = (state_q == ST_HOLD);
        sda_oe     = (state_q == ST_ACK) || (state_q == ST_TX && !sh_q[DATA_W-1]);
        host_rdata = rx_q;
        irq        = irq_q;
        busy       = busy_q;
        addr_match = match_q;
        rw_flag    = rw_q;
        tout_flag  = tout_q;
    end
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic scl_oe,
    input logic sda_oe,
    input logic tx_mode,
    input logic host_wr,
    input logic host_rd,
    input logic irq,
    input logic busy,
    input logic addr_match,
    input logic tout_flag
);
    a_r2_quiet_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe));

    a_r2_match_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        addr_match |-> busy);

    a_r5_hold_has_irq: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe |-> irq);

    a_r5_write_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_oe && tx_mode && host_wr) |=> !scl_oe);

    a_r6_wrong_strobe_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_oe && !tx_mode && host_wr && !host_rd) |=> (scl_oe || tout_flag));

    a_r8_sda_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i) && !$rose(tout_flag)) |-> $stable(sda_oe));

    a_r10_tout_releases: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tout_flag) |-> (irq && !scl_oe && !sda_oe));
endmodule

bind i2c_stretch_slave i2cs_checker u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .tx_mode(tx_mode), .host_wr(host_wr), .host_rd(host_rd), .irq(irq),
    .busy(busy), .addr_match(addr_match), .tout_flag(tout_flag)
);

// File: tb/sim_i2c_stretch_slave.sv
`timescale 1ns/1ps
module sim_i2c_stretch_slave;
    localparam int H    = 12;
    localparam int TOUT = 200;
    localparam logic [6:0] OWN = 7'h5A;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n, m_scl_low, m_sda_low;
    logic       tx_mode, host_wr, host_rd, irq_clr;
    logic [7:0] host_wdata, host_rdata;
    logic       scl_oe, sda_oe, irq, busy, addr_match, rw_flag, tout_flag;
    logic       scl_line, sda_line;
    logic [15:0] tout_limit;
    logic [6:0] own_addr;

    assign scl_line = !(m_scl_low || scl_oe);
    assign sda_line = !(m_sda_low || sda_oe);

    i2c_stretch_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(own_addr), .tx_mode(tx_mode),
        .tout_limit(tout_limit), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_rdata(host_rdata), .irq_clr(irq_clr), .irq(irq),
        .busy(busy), .addr_match(addr_match), .rw_flag(rw_flag), .tout_flag(tout_flag)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start();
        m_scl_low = 1'b0; m_sda_low = 1'b0; wt(H);
        m_sda_low = 1'b1; wt(H);
        m_scl_low = 1'b1; wt(H);
    endtask

    task automatic m_stop();
        m_sda_low = 1'b1; wt(H);
        m_scl_low = 1'b0;
        while (!scl_line) @(negedge clk);
        wt(H);
        m_sda_low = 1'b0; wt(H);
    endtask

    task automatic m_bit(input logic b, output logic r);
        m_sda_low = !b; wt(H);
        m_scl_low = 1'b0;
        while (!scl_line) @(negedge clk);
        wt(H/2);
        r = sda_line;
        wt(H/2);
        m_scl_low = 1'b1;
    endtask

    task automatic m_wbyte(input logic [7:0] d, output logic acked);
        logic r;
        for (int i = 7; i >= 0; i--) m_bit(d[i], r);
        m_bit(1'b1, r);
        acked = !r;
    endtask

    task automatic m_rbyte(output logic [7:0] d, input logic give_ack);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            m_bit(1'b1, r);
            d[i] = r;
        end
        m_bit(!give_ack, r);
    endtask

    task automatic h_write(input logic [7:0] d);
        @(negedge clk); host_wr = 1'b1; host_wdata = d;
        @(negedge clk); host_wr = 1'b0;
    endtask

    task automatic h_read(output logic [7:0] d);
        @(negedge clk); d = host_rdata; host_rd = 1'b1;
        @(negedge clk); host_rd = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        wt(190000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        logic       acked, r;
        logic [7:0] got, d;
        rst_n = 1'b0; m_scl_low = 1'b0; m_sda_low = 1'b0;
        tx_mode = 1'b0; host_wr = 1'b0; host_rd = 1'b0; irq_clr = 1'b0;
        host_wdata = 8'h00; tout_limit = 16'(TOUT); own_addr = OWN;
        wt(5); rst_n = 1'b1; wt(5);

        // R1 reset state
        chk(irq == 0 && busy == 0 && addr_match == 0, "R1 flags", {irq, busy, addr_match}, 0);
        chk(rw_flag == 0 && tout_flag == 0, "R1 rw/tout", {rw_flag, tout_flag}, 0);
        chk(scl_oe == 0 && sda_oe == 0, "R1 no drive", {scl_oe, sda_oe}, 0);

        // R2 R3 R4 R5: sweep of every first byte
        for (int f = 0; f < 256; f++) begin
            logic [7:0] fb;
            logic       hit;
            fb  = 8'(f);
            hit = (fb[7:1] == OWN);
            m_start();
            chk(busy == 1, "R2 busy after start", busy, 1);
            m_wbyte(fb, acked);
            chk(acked == hit, "R3 address ack", acked, hit);
            wt(8);
            if (hit) begin
                chk(irq && addr_match && scl_oe, "R5 hold on match", {irq, addr_match, scl_oe}, 7);
                chk(rw_flag == fb[0], "R4 direction bit", rw_flag, fb[0]);
                chk(tout_flag == 0, "R10 no early timeout", tout_flag, 0);
                if (fb[0]) begin
                    tx_mode = 1'b1;
                    h_write(8'hFF);
                end else begin
                    tx_mode = 1'b0;
                    h_read(got);
                end
                wt(2);
                chk(!scl_oe && !irq && !addr_match, "R5 release", {scl_oe, irq, addr_match}, 0);
            end else begin
                chk(!irq && !scl_oe, "R3 mismatch quiet", {irq, scl_oe}, 0);
            end
            m_stop();
            wt(4);
            chk(busy == 0 && addr_match == 0, "R2 stop clears", {busy, addr_match}, 0);
            tx_mode = 1'b0;
        end

        // R6 R7: receive run
        m_start();
        m_wbyte({OWN, 1'b0}, acked);
        wt(8);
        h_write(8'h00);
        wt(2);
        chk(scl_oe && irq, "R6 host_wr ignored in receive", {scl_oe, irq}, 3);
        h_read(got);
        for (int k = 0; k < 16; k++) begin
            d = 8'(k) * 8'd37 + 8'd11;
            m_wbyte(d, acked);
            chk(acked == 1, "R7 byte acknowledged", acked, 1);
            wt(8);
            chk(irq && scl_oe && !addr_match, "R7 hold after byte", {irq, scl_oe, addr_match}, 6);
            h_read(got);
            chk(got == d, "R7 received data", got, d);
        end
        m_stop();
        wt(4);

        // R6 R8 R9: transmit run
        m_start();
        m_wbyte({OWN, 1'b1}, acked);
        wt(8);
        chk(rw_flag == 1, "R4 read direction", rw_flag, 1);
        tx_mode = 1'b1;
        h_read(got);
        wt(2);
        chk(scl_oe && irq, "R6 host_rd ignored in transmit", {scl_oe, irq}, 3);
        h_write(8'h96);
        for (int k = 0; k < 8; k++) begin
            d = 8'(k) * 8'd53 + 8'h96;
            m_rbyte(got, k != 7);
            chk(got == d, "R8 transmitted data", got, d);
            wt(8);
            if (k != 7) begin
                chk(irq && scl_oe, "R8 hold after master ack", {irq, scl_oe}, 3);
                h_write(8'(k + 1) * 8'd53 + 8'h96);
            end else begin
                chk(!scl_oe && !sda_oe && !irq, "R9 release on nack", {scl_oe, sda_oe, irq}, 0);
            end
        end
        m_stop();
        wt(4);
        chk(busy == 0, "R2 busy after transmit stop", busy, 0);
        tx_mode = 1'b0;

        // R10: time-out while slave holds SCL
        m_start();
        m_wbyte({OWN, 1'b0}, acked);
        wt(8);
        chk(scl_oe == 1 && tout_flag == 0, "R10 holding before timeout", {scl_oe, tout_flag}, 2);
        wt(TOUT + 20);
        chk(tout_flag && irq, "R10 timeout flags", {tout_flag, irq}, 3);
        chk(!scl_oe && !sda_oe, "R10 lines released", {scl_oe, sda_oe}, 0);
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        wt(1);
        chk(!irq && !tout_flag, "R10 irq_clr", {irq, tout_flag}, 0);
        m_stop();
        wt(4);
        chk(busy == 0, "R2 stop after timeout", busy, 0);

        // R10: time-out with SCL abandoned high mid-address
        m_start();
        m_bit(1'b1, r); m_bit(1'b1, r); m_bit(1'b1, r);
        m_scl_low = 1'b0;
        wt(TOUT + 20);
        chk(tout_flag && irq && !sda_oe, "R10 timeout with SCL high", {tout_flag, irq, sda_oe}, 6);
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        m_scl_low = 1'b1; wt(H);
        m_stop();
        wt(4);
        chk(busy == 0 && irq == 0, "R2 idle at end", {busy, irq}, 0);

        summary();
        $finish;
    end
endmodule